// File: doc/BRIEF.md
# Shared Free-Running Noise Generator with Scrambled Views

This block holds a single 128-bit xoroshiro128+ style pseudo-random state that steps once on every rising clock edge, whether or not any consumer uses it. The two 64-bit halves are added together. Bits 63 down to 1 of that sum form a 63-bit result. The lowest sum bit is weak, so it is dropped.

Many consumers share the one generator. Each consumer receives its own fixed permutation of the result. There are sixteen 32-bit processor views, in which some bits are inverted. There are also a number of 8-bit pin views meant for dither and noise. All views can be sampled in the same cycle, and each one differs from the others.

At start-up, an entropy source feeds a series of injections. Each injection XORs 31 entropy bits into one selected 32-bit quarter of the state. After a programmed number of injections, the seeding path closes and the generator simply runs.

Top module: `shared_noise_gen`

## Requirements
- R1: While `rst_n` is low the state equals parameter `RESET_SEED` (low half is bits 63:0, high half is bits 127:64), `seed_done` is 0 and `result` reflects that state.
- R2: On every rising clock edge out of reset, with low half `L` and high half `H`, let `t = L ^ H`. The new low half is `rotl(L,24) ^ t ^ (t<<16)` and the new high half is `rotl(t,37)`.
- R3: `result` equals bits 63:1 of the 64-bit sum `L + H` of the current state.
- R4: Processor port k (bits `32k+j` of `cpu_rnd`) bit j is `result[(3k + j*m) mod 63]`, where m is the smallest integer ≥ k+1 divisible by neither 3 nor 7. The bit is inverted when `(3j + k) mod 5 == 0`.
- R5: Pin port k (bits `8k+j` of `pin_rnd`) bit j is `result[(11k + j*p) mod 63]`, where p is the smallest integer ≥ k+2 divisible by neither 3 nor 7. No pin bit is inverted.
- R6: When `seed_valid` is high and `seed_done` is low, the stepped state has its quarter `seed_quarter` (bits `32q+31:32q`) XORed with `{1'b0, seed_pvt, seed_noise}` before it is stored.
- R7: `seed_done` goes to 1 at the edge that accepts the `SEED_ROUNDS`-th injection and stays at 1. After that, `seed_valid` has no effect on the state.
- R8: If the next state would be all zero, the value 128'h1 is stored instead.
- R9: In any single cycle, all sixteen processor views present different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the state steps on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid | input | 1 | Entropy injection strobe |
| seed_quarter | input | 2 | Quarter of the state that receives the injection |
| seed_noise | input | 4 | Thermal-noise entropy bits |
| seed_pvt | input | 27 | Process/voltage/temperature dependent bits |
| seed_done | output | 1 | Seeding finished; injections are closed |
| result | output | 63 | Upper 63 bits of the half-sum |
| cpu_rnd | output | NUM_CPU*32 | Scrambled 32-bit processor views, port k in bits 32k+31:32k |
| pin_rnd | output | NUM_PIN*8 | Scrambled 8-bit pin views, port k in bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is the zero-state guard. Starting from a sane seed, no run of quarter-wide XOR injections reaches an all-zero successor in any practical time. The bench therefore runs a second instance whose reset seed is all zero. Its first step has to land on the replacement constant, and the state then continues from there. That instance is checked against the reference model cycle by cycle, next to the normally seeded instance, whose 64 injections cycle through all four quarters with varying entropy words.

// File: rtl/shared_noise_gen.sv
module shared_noise_gen #(
  parameter int NUM_CPU = 16,
  parameter int NUM_PIN = 8,
  parameter int CPU_W = 32,
  parameter int PIN_W = 8,
  parameter int SEED_ROUNDS = 64,
  parameter logic [127:0] RESET_SEED = 128'h9E3779B97F4A7C15_D1B54A32D192ED03
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seed_valid,
  input  logic [1:0]               seed_quarter,
  input  logic [3:0]               seed_noise,
  input  logic [26:0]              seed_pvt,
  output logic                     seed_done,
  output logic [62:0]              result,
  output logic [NUM_CPU*CPU_W-1:0] cpu_rnd,
  output logic [NUM_PIN*PIN_W-1:0] pin_rnd
);
  localparam int RES_W = 63;
  localparam int CW = $clog2(SEED_ROUNDS + 1);

  function automatic int coprime_from(int v);
    int s = v;
    for (int i = 0; i < 8; i++)
      if ((s % 3 == 0) || (s % 7 == 0)) s++;
    return s;
  endfunction

  logic [127:0] st_q, st_next;
  logic [63:0]  lo, hi, t, n_lo, n_hi;
  logic [CW-1:0] cnt_q;
  logic          take;

  assign lo = st_q[63:0];
  assign hi = st_q[127:64];
  assign t = lo ^ hi;
  assign n_lo = {lo[39:0], lo[63:40]} ^ t ^ (t << 16);
  assign n_hi = {t[26:0], t[63:27]};
  assign seed_done = (cnt_q == CW'(SEED_ROUNDS));
  assign take = seed_valid && !seed_done;
  assign result = 63'((lo + hi) >> 1);

  always_comb begin
    st_next = {n_hi, n_lo};
    if (take) st_next[{seed_quarter, 5'b0} +: 32] = st_next[{seed_quarter, 5'b0} +: 32] ^ {1'b0, seed_pvt, seed_noise};
    if (st_next == '0) st_next = 128'h1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RESET_SEED;
      cnt_q <= '0;
    end else begin
      st_q <= st_next;
      if (take) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    localparam int M = coprime_from(k + 1);
    for (genvar j = 0; j < CPU_W; j++) begin : g_bit
      localparam int IDX = (3 * k + j * M) % RES_W;
      localparam bit INV = ((3 * j + k) % 5) == 0;
      assign cpu_rnd[k*CPU_W+j] = result[IDX] ^ INV;
    end
  end

  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    localparam int P = coprime_from(k + 2);
    for (genvar j = 0; j < PIN_W; j++) begin : g_bit
      localparam int IDX = (11 * k + j * P) % RES_W;
      assign pin_rnd[k*PIN_W+j] = result[IDX];
    end
  end
endmodule

module shared_noise_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         seed_valid,
  input logic         seed_done,
  input logic [127:0] st_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n) (age != 2'd0) |-> (st_q != '0));
  p_moves_r2: assert property (@(posedge clk) disable iff (!rst_n) (age >= 2'd2) |-> (st_q != $past(st_q)));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) seed_done |=> seed_done);
  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(seed_done) |-> $past(seed_valid));
endmodule

bind shared_noise_gen shared_noise_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_done(seed_done), .st_q(st_q)
);

// File: tb/shared_noise_gen_tb_top.sv
`timescale 1ns/1ps
module shared_noise_gen_tb_top;
  localparam int NC = 16, NP = 8, ROUNDS = 64;
  localparam logic [127:0] RSEED = 128'h9E3779B97F4A7C15_D1B54A32D192ED03;

  logic clk = 0, rst_n = 0, sv = 0;
  logic [1:0] sq = 0;
  logic [3:0] sn = 0;
  logic [26:0] sp = 0;
  logic done_a, done_z;
  logic [62:0] res_a, res_z;
  logic [NC*32-1:0] cpu_a, cpu_z;
  logic [NP*8-1:0] pin_a, pin_z;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shared_noise_gen dut_i (.clk(clk), .rst_n(rst_n), .seed_valid(sv), .seed_quarter(sq),
    .seed_noise(sn), .seed_pvt(sp), .seed_done(done_a), .result(res_a), .cpu_rnd(cpu_a), .pin_rnd(pin_a));
  shared_noise_gen #(.RESET_SEED(128'h0)) dut_z (.clk(clk), .rst_n(rst_n), .seed_valid(1'b0),
    .seed_quarter(2'd0), .seed_noise(4'd0), .seed_pvt(27'd0), .seed_done(done_z), .result(res_z),
    .cpu_rnd(cpu_z), .pin_rnd(pin_z));

  function automatic logic [127:0] m_step(logic [127:0] s);
    logic [63:0] l = s[63:0], h = s[127:64], x;
    x = l ^ h;
    return {((x << 37) | (x >> 27)), (((l << 24) | (l >> 40)) ^ x ^ (x << 16))};
  endfunction
  function automatic logic [62:0] m_res(logic [127:0] s);
    logic [63:0] sum = s[63:0] + s[127:64];
    return sum[63:1];
  endfunction
  function automatic int m_cop(int v);
    int s = v;
    while ((s % 3 == 0) || (s % 7 == 0)) s++;
    return s;
  endfunction
  function automatic logic [31:0] m_cpu(logic [62:0] r, int k);
    logic [31:0] o;
    for (int j = 0; j < 32; j++) o[j] = r[(3*k + j*m_cop(k+1)) % 63] ^ (((3*j + k) % 5) == 0);
    return o;
  endfunction
  function automatic logic [7:0] m_pin(logic [62:0] r, int k);
    logic [7:0] o;
    for (int j = 0; j < 8; j++) o[j] = r[(11*k + j*m_cop(k+2)) % 63];
    return o;
  endfunction

  logic [127:0] ma, mz, nx;
  int mcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma <= RSEED; mz <= '0; mcnt <= 0;
    end else begin
      nx = m_step(ma);
      if (sv && mcnt < ROUNDS) begin
        nx[sq*32 +: 32] = nx[sq*32 +: 32] ^ {1'b0, sp, sn};
        mcnt <= mcnt + 1;
      end
      if (nx == '0) nx = 128'h1;
      ma <= nx;
      nx = m_step(mz);
      if (nx == '0) nx = 128'h1;
      mz <= nx;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmp_a(string req);
    chk(res_a == m_res(ma), req, "result", 128'(res_a), 128'(m_res(ma)));
    chk(done_a == (mcnt >= ROUNDS), req, "seed_done", 128'(done_a), 128'(mcnt >= ROUNDS));
    for (int k = 0; k < NC; k++)
      chk(cpu_a[k*32 +: 32] == m_cpu(m_res(ma), k), req, $sformatf("cpu%0d", k),
          128'(cpu_a[k*32 +: 32]), 128'(m_cpu(m_res(ma), k)));
    for (int k = 0; k < NP; k++)
      chk(pin_a[k*8 +: 8] == m_pin(m_res(ma), k), req, $sformatf("pin%0d", k),
          128'(pin_a[k*8 +: 8]), 128'(m_pin(m_res(ma), k)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done_a == 1'b0, "R1", "seed_done in reset", 128'(done_a), 128'(0));
    chk(res_a == m_res(RSEED), "R1", "result in reset", 128'(res_a), 128'(m_res(RSEED)));
    cmp_a("R1");
  endtask

  task automatic t_free_run();
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      cmp_a("R2 R3 R4 R5");
    end
  endtask

  task automatic t_distinct();
    @(negedge clk);
    for (int a = 0; a < NC; a++)
      for (int b = a + 1; b < NC; b++)
        chk(cpu_a[a*32 +: 32] != cpu_a[b*32 +: 32], "R9", $sformatf("views %0d/%0d differ", a, b),
            128'(cpu_a[a*32 +: 32]), 128'(cpu_a[b*32 +: 32]));
  endtask

  task automatic t_seed();
    for (int i = 0; i < ROUNDS; i++) begin
      @(negedge clk);
      cmp_a("R6");
      chk(done_a == 1'b0, "R7", "done before last injection", 128'(done_a), 128'(0));
      sv = 1; sq = 2'(i); sn = 4'(i * 7 + 3); sp = 27'(32'h5A5A123 ^ (i * 32'h1F3D5));
    end
    @(negedge clk);
    chk(done_a == 1'b1, "R7", "done after last injection", 128'(done_a), 128'(1));
    cmp_a("R6");
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 10; i++) begin
      sv = 1; sq = 2'(i); sn = 4'hF; sp = 27'h7FFFFFF - 27'(i);
      @(negedge clk);
      cmp_a("R7 ignored");
    end
    sv = 0;
  endtask

  task automatic t_zero();
    @(negedge clk);
    for (int c = 0; c < 12; c++) begin
      chk(res_z == m_res(mz), "R8", "zero-seeded result", 128'(res_z), 128'(m_res(mz)));
      chk(cpu_z[31:0] == m_cpu(m_res(mz), 0), "R8", "zero-seeded cpu0", 128'(cpu_z[31:0]), 128'(m_cpu(m_res(mz), 0)));
      @(negedge clk);
    end
    chk(res_z != '0, "R8", "zero-seeded output nonzero", 128'(res_z), 128'(m_res(mz)));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    fork
      t_zero();
      begin
        t_free_run();
        t_distinct();
        t_seed();
        t_ignore();
        t_free_run();
      end
    join
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule